// File: doc/BRIEF.md
# Streaming Firmware Image Loader

The loader accepts a firmware image one 32-bit word per cycle and checks it before its contents reach the processing engine's two memories. The image starts with three header words: a signature, an identity word and a payload length in words. Next comes a table of block descriptors, each a type word and an offset word, closed by a single end word. The code and data blocks follow, each made of a target address, a word count and the words to store. Every check is made as the words stream past, and block contents go straight to a write port with no buffering of the image.

Software pulses `start` and gives the expected image length in words, then streams the image. An image whose signature arrives byte-reversed is accepted, and every later word is byte-reversed back before use. The loader ends each attempt with a one-cycle `done` pulse and an error code. A clean load also pulses `eng_start` so the engine starts running. Offsets in the table count in words from the first word after the header. Because the image is never stored, blocks must appear in the stream in the same order as their table entries.

Top module: `flp_loader`

## Requirements
- R1: A first word of 0xFEEDF00D selects normal order, and 0x0DF0EDFE makes the loader byte-reverse every later word. Any other first word ends the load with code 1.
- R2: The payload length field plus 3 must equal `img_words`, or the load ends with code 2 at the length word. A block whose word count runs past the end of the payload also ends the load with code 2.
- R3: Identity bits 27:24 must equal `cfg_engine`. When SMALL_MEM is 1, identity bits 31:28 must be zero. Either failure gives code 3.
- R4: A table type word of 0 marks an instruction block, 1 marks a data block and 0xF ends the table. Any other value gives code 5.
- R5: The load ends with code 8 if the payload ends before the end word, or if more than MAX_BLOCKS descriptors come before the end word. A payload length of zero also gives code 8.
- R6: An offset plus 2 must not exceed the payload length. A block's offset must be at or past the word after the end word and at or past the current stream position, so blocks come in ascending order. Otherwise the load ends with code 4, and a block still unreached when the image ends also gives code 4.
- R7: A block whose address plus word count exceeds its memory size ends the load with code 6 before any of its words are written. Each memory holds 2048 words when SMALL_MEM is 1 and 4096 otherwise.
- R8: Each block word produces one `wr_en` cycle, one cycle after the word is accepted. Word j goes to address+j, with `wr_dmem` high for data blocks and low for instruction blocks.
- R9: A `start` while `eng_running` is high gives `done` with code 7 on the next cycle, and no words are written.
- R10: On success, `done` with code 0 and `eng_start` pulse together one cycle after the last image word. After an error, `eng_start` stays low.
- R11: After `done`, incoming words are ignored and nothing is written until the next `start`.
- R12: During reset and straight after it, `wr_en`, `done` and `eng_start` are low and `err_code` is 0.
- R13: Words between blocks and words after the last block are skipped. A block with a word count of zero writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new load attempt |
| img_words | input | IMG_W | Expected image length in words, sampled on `start` |
| cfg_engine | input | 4 | Engine number the identity word must carry |
| eng_running | input | 1 | Engine is executing, so loading is refused |
| in_valid | input | 1 | `in_data` holds an image word this cycle |
| in_data | input | 32 | Image word |
| wr_en | output | 1 | Memory write strobe |
| wr_dmem | output | 1 | 1 selects the data memory, 0 the instruction memory |
| wr_addr | output | ADDR_W | Memory word address |
| wr_data | output | 32 | Word to store |
| done | output | 1 | One-cycle end-of-attempt pulse |
| err_code | output | 4 | Result of the last attempt, 0 meaning success |
| eng_start | output | 1 | One-cycle engine start request |

## Verification
The properties assume that `start` comes as an isolated pulse and that the image does not restart while it is still streaming. The bench keeps to this by raising `start` for a single cycle and streaming each image only after `start` has dropped. They also assume that `eng_running` does not change during an attempt, and the bench changes it only while the loader is idle. Stream words may keep arriving after an error. The bench sends every image in full even when the loader should stop early, so the ignore rule is checked on real traffic.

// File: rtl/flp_pkg.sv
package flp_pkg;

    localparam logic [31:0] FW_SIGNATURE = 32'hFEEDF00D;
    localparam logic [31:0] FW_SIGNATURE_REV = 32'h0DF0EDFE;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_MAGIC    = 4'd1,
        ERR_LENGTH   = 4'd2,
        ERR_ENGINE   = 4'd3,
        ERR_OFFSET   = 4'd4,
        ERR_TYPE     = 4'd5,
        ERR_OVERFLOW = 4'd6,
        ERR_BUSY     = 4'd7,
        ERR_NO_END   = 4'd8
    } flp_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SIGN,
        ST_IDENT,
        ST_LEN,
        ST_TTYPE,
        ST_TOFF,
        ST_SEEK,
        ST_BCOUNT,
        ST_BDATA
    } flp_state_e;

endpackage

// File: rtl/flp_word_norm.sv
module flp_word_norm #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] in_word,
    input  logic               reverse,
    output logic [8*LANES-1:0] out_word
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign out_word[8*b +: 8] = reverse ? in_word[8*(LANES-1-b) +: 8]
                                            : in_word[8*b +: 8];
    end
endmodule

// File: rtl/flp_block_table.sv
module flp_block_table #(
    parameter int DEPTH = 8,
    parameter int OFF_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic             wr_is_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [OFF_W-1:0] rd_off,
    output logic             rd_is_data
);
    logic [OFF_W-1:0] off_q  [DEPTH];
    logic             kind_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q[e]  <= '0;
                kind_q[e] <= 1'b0;
            end else if (we && (wr_idx == IDX_W'(e))) begin
                off_q[e]  <= wr_off;
                kind_q[e] <= wr_is_data;
            end
        end
    end

    always_comb begin
        rd_off     = '0;
        rd_is_data = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_off     = off_q[i];
                rd_is_data = kind_q[i];
            end
        end
    end
endmodule

// File: rtl/flp_bound_chk.sv
module flp_bound_chk #(
    parameter int IMG_W      = 16,
    parameter int IMEM_WORDS = 2048,
    parameter int DMEM_WORDS = 2048
) (
    input  logic [31:0]      base,
    input  logic [31:0]      count,
    input  logic             is_data,
    input  logic [IMG_W-1:0] pos,
    input  logic [IMG_W-1:0] size,
    output logic             mem_over,
    output logic             img_over
);
    localparam logic [32:0] ILIM = 33'(IMEM_WORDS);
    localparam logic [32:0] DLIM = 33'(DMEM_WORDS);

    logic [32:0] mem_end;
    logic [32:0] img_end;

    always_comb begin
        mem_end  = {1'b0, base} + {1'b0, count};
        img_end  = {1'b0, count} + 33'(pos) + 33'd1;
        mem_over = mem_end > (is_data ? DLIM : ILIM);
        img_over = img_end > 33'(size);
    end
endmodule

// File: rtl/flp_loader.sv
module flp_loader
    import flp_pkg::*;
#(
    parameter int SMALL_MEM  = 1,
    parameter int MAX_BLOCKS = 8,
    parameter int IMG_W      = 16,
    localparam int MEM_WORDS = (SMALL_MEM != 0) ? 2048 : 4096,
    localparam int ADDR_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IMG_W-1:0]  img_words,
    input  logic [3:0]        cfg_engine,
    input  logic              eng_running,
    input  logic              in_valid,
    input  logic [31:0]       in_data,
    output logic              wr_en,
    output logic              wr_dmem,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic [3:0]        err_code,
    output logic              eng_start
);
    localparam int CNT_W = $clog2(MAX_BLOCKS + 1);
    localparam logic [IMG_W-1:0] POS_ONE = IMG_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BLOCKS);

    typedef struct packed {
        flp_state_e       st;
        logic             rev;
        logic [IMG_W-1:0] want;
        logic [IMG_W-1:0] size;
        logic [IMG_W-1:0] pos;
        logic [CNT_W-1:0] nblk;
        logic [CNT_W-1:0] cur;
        logic             pend_data;
        logic [31:0]      base;
        logic [ADDR_W-1:0] waddr;
        logic [IMG_W-1:0] left;
        logic             wr_en;
        logic             wr_dmem;
        logic [ADDR_W-1:0] wr_addr;
        logic [31:0]      wr_data;
        logic             done;
        flp_err_e         err;
        logic             eng_start;
    } regs_t;

    regs_t q, d;

    logic [31:0]      word;
    logic             tab_we;
    logic [IMG_W-1:0] ent_off;
    logic             ent_data;
    logic             mem_over;
    logic             img_over;
    logic             last;
    logic             fin;
    flp_err_e         fin_err;
    logic [CNT_W-1:0] nxt_cur;

    flp_word_norm #(.LANES(4)) u_norm (
        .in_word  (in_data),
        .reverse  (q.rev),
        .out_word (word)
    );

    flp_block_table #(.DEPTH(MAX_BLOCKS), .OFF_W(IMG_W), .IDX_W(CNT_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (tab_we),
        .wr_idx     (q.nblk),
        .wr_off     (word[IMG_W-1:0]),
        .wr_is_data (q.pend_data),
        .rd_idx     (q.cur),
        .rd_off     (ent_off),
        .rd_is_data (ent_data)
    );

    flp_bound_chk #(.IMG_W(IMG_W), .IMEM_WORDS(MEM_WORDS), .DMEM_WORDS(MEM_WORDS)) u_bound (
        .base     (q.base),
        .count    (word),
        .is_data  (ent_data),
        .pos      (q.pos),
        .size     (q.size),
        .mem_over (mem_over),
        .img_over (img_over)
    );

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.done    = 1'b0;
        d.eng_start = 1'b0;
        tab_we    = 1'b0;
        fin       = 1'b0;
        fin_err   = ERR_NONE;
        nxt_cur   = q.cur + CNT_ONE;
        last      = (q.pos + POS_ONE) == q.size;

        if (start) begin
            if (eng_running) begin
                fin     = 1'b1;
                fin_err = ERR_BUSY;
            end else begin
                d.st   = ST_SIGN;
                d.want = img_words;
                d.rev  = 1'b0;
            end
        end else if (in_valid && (q.st != ST_IDLE)) begin
            if (q.st >= ST_TTYPE) d.pos = q.pos + POS_ONE;
            case (q.st)
                ST_SIGN: begin
                    if (in_data == FW_SIGNATURE) begin
                        d.st = ST_IDENT;
                    end else if (in_data == FW_SIGNATURE_REV) begin
                        d.st  = ST_IDENT;
                        d.rev = 1'b1;
                    end else begin
                        fin = 1'b1; fin_err = ERR_MAGIC;
                    end
                end
                ST_IDENT: begin
                    if ((word[27:24] != cfg_engine) ||
                        ((SMALL_MEM != 0) && (word[31:28] != 4'd0))) begin
                        fin = 1'b1; fin_err = ERR_ENGINE;
                    end else begin
                        d.st = ST_LEN;
                    end
                end
                ST_LEN: begin
                    if (({1'b0, word} + 33'd3) != 33'(q.want)) begin
                        fin = 1'b1; fin_err = ERR_LENGTH;
                    end else if (word == 32'd0) begin
                        fin = 1'b1; fin_err = ERR_NO_END;
                    end else begin
                        d.st   = ST_TTYPE;
                        d.size = word[IMG_W-1:0];
                        d.pos  = '0;
                        d.nblk = '0;
                        d.cur  = '0;
                    end
                end
                ST_TTYPE: begin
                    if (word == 32'hF) begin
                        d.st = ST_SEEK;
                        if (last) begin
                            fin     = 1'b1;
                            fin_err = (q.nblk == '0) ? ERR_NONE : ERR_OFFSET;
                        end
                    end else if ((word == 32'd0) || (word == 32'd1)) begin
                        if ((q.nblk == CNT_MAX) || last) begin
                            fin = 1'b1; fin_err = ERR_NO_END;
                        end else begin
                            d.pend_data = word[0];
                            d.st        = ST_TOFF;
                        end
                    end else begin
                        fin = 1'b1; fin_err = ERR_TYPE;
                    end
                end
                ST_TOFF: begin
                    if (({1'b0, word} + 33'd2) > 33'(q.size)) begin
                        fin = 1'b1; fin_err = ERR_OFFSET;
                    end else if (last) begin
                        fin = 1'b1; fin_err = ERR_NO_END;
                    end else begin
                        tab_we = 1'b1;
                        d.nblk = q.nblk + CNT_ONE;
                        d.st   = ST_TTYPE;
                    end
                end
                ST_SEEK: begin
                    if (q.cur == q.nblk) begin
                        if (last) fin = 1'b1;
                    end else if (ent_off < q.pos) begin
                        fin = 1'b1; fin_err = ERR_OFFSET;
                    end else if (ent_off == q.pos) begin
                        d.base = word;
                        d.st   = ST_BCOUNT;
                    end
                end
                ST_BCOUNT: begin
                    if (mem_over) begin
                        fin = 1'b1; fin_err = ERR_OVERFLOW;
                    end else if (img_over) begin
                        fin = 1'b1; fin_err = ERR_LENGTH;
                    end else if (word == 32'd0) begin
                        d.cur = nxt_cur;
                        d.st  = ST_SEEK;
                        if (last) begin
                            fin     = 1'b1;
                            fin_err = (nxt_cur == q.nblk) ? ERR_NONE : ERR_OFFSET;
                        end
                    end else begin
                        d.left  = word[IMG_W-1:0];
                        d.waddr = q.base[ADDR_W-1:0];
                        d.st    = ST_BDATA;
                    end
                end
                ST_BDATA: begin
                    d.wr_en   = 1'b1;
                    d.wr_dmem = ent_data;
                    d.wr_addr = q.waddr;
                    d.wr_data = word;
                    d.waddr   = q.waddr + ADDR_W'(1);
                    d.left    = q.left - POS_ONE;
                    if (q.left == POS_ONE) begin
                        d.cur = nxt_cur;
                        d.st  = ST_SEEK;
                        if (last) begin
                            fin     = 1'b1;
                            fin_err = (nxt_cur == q.nblk) ? ERR_NONE : ERR_OFFSET;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end

        if (fin) begin
            d.st        = ST_IDLE;
            d.done      = 1'b1;
            d.err       = fin_err;
            d.eng_start = (fin_err == ERR_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en     = q.wr_en;
    assign wr_dmem   = q.wr_dmem;
    assign wr_addr   = q.wr_addr;
    assign wr_data   = q.wr_data;
    assign done      = q.done;
    assign err_code  = q.err;
    assign eng_start = q.eng_start;
endmodule

// File: rtl/flp_loader_chk.sv
module flp_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       eng_running,
    input logic       in_valid,
    input logic       wr_en,
    input logic       done,
    input logic [3:0] err_code,
    input logic       eng_start
);
    AST_BUSY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && eng_running) |=> (done && err_code == 4'd7)); // R9

    AST_START_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (done && err_code == 4'd0)); // R10

    AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 4'd0) |-> !eng_start); // R10

    AST_WR_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid)); // R8

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_en); // R11
endmodule

bind flp_loader flp_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .eng_running (eng_running),
    .in_valid    (in_valid),
    .wr_en       (wr_en),
    .done        (done),
    .err_code    (err_code),
    .eng_start   (eng_start)
);

// File: tb/flp_loader_tb.sv
module flp_loader_tb;
    localparam int IMG_W  = 16;
    localparam int ADDR_W = 11;
    localparam logic [31:0] SIG = 32'hFEEDF00D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IMG_W-1:0]  img_words = '0;
    logic [3:0]        cfg_engine = 4'd2;
    logic              eng_running = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_data = '0;
    logic              wr_en, wr_dmem, done, eng_start;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic [3:0]        err_code;

    always #4 clk = ~clk;

    flp_loader #(.SMALL_MEM(1), .MAX_BLOCKS(8), .IMG_W(IMG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_words(img_words),
        .cfg_engine(cfg_engine), .eng_running(eng_running),
        .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_dmem(wr_dmem), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .err_code(err_code), .eng_start(eng_start)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] img [0:63];

    // fields: swap, bad signature, engine, device, length delta (0 exact, 1 +1, 2 -1), expected code
    localparam logic [15:0] VEC [0:7] = '{
        {1'b0, 1'b0, 4'd2, 4'd0, 2'd0, 4'd0},
        {1'b1, 1'b0, 4'd2, 4'd0, 2'd0, 4'd0},
        {1'b0, 1'b1, 4'd2, 4'd0, 2'd0, 4'd1},
        {1'b0, 1'b0, 4'd3, 4'd0, 2'd0, 4'd3},
        {1'b0, 1'b0, 4'd2, 4'd1, 2'd0, 4'd3},
        {1'b0, 1'b0, 4'd2, 4'd0, 2'd1, 4'd2},
        {1'b1, 1'b0, 4'd5, 4'd0, 2'd0, 4'd3},
        {1'b1, 1'b0, 4'd2, 4'd0, 2'd2, 4'd2}
    };

    // monitor
    int pcyc = 0, last_acc = 0, done_at = 0;
    int n_wr = 0, done_cnt = 0, start_cnt = 0;
    logic [3:0]  err_last = '0;
    logic        log_dm [0:15];
    logic [ADDR_W-1:0] log_ad [0:15];
    logic [31:0] log_da [0:15];

    always @(posedge clk) begin
        pcyc = pcyc + 1;
        if (in_valid) last_acc = pcyc;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (n_wr < 16) begin
                    log_dm[n_wr] = wr_dmem;
                    log_ad[n_wr] = wr_addr;
                    log_da[n_wr] = wr_data;
                end
                n_wr = n_wr + 1;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                err_last = err_code;
                done_at  = pcyc;
            end
            if (eng_start) start_cnt = start_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rev32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic hdr(input int sz);
        for (int i = 0; i < 64; i++) img[i] = 32'd0;
        img[0] = SIG;
        img[1] = {4'd0, 4'd2, 24'h000101};
        img[2] = sz;
    endtask

    task automatic build_std(input bit sw, input bit bad, input logic [3:0] eng, input logic [3:0] dev);
        hdr(12);
        if (bad) img[0] = 32'h12345678;
        img[1] = {dev, eng, 24'h0A0B0C};
        img[3]  = 32'd0;  img[4]  = 32'd5;
        img[5]  = 32'd1;  img[6]  = 32'd9;
        img[7]  = 32'hF;
        img[8]  = 32'h10; img[9]  = 32'd2;
        img[10] = 32'hA0A00001; img[11] = 32'hA0A00002;
        img[12] = 32'h7FF; img[13] = 32'd1;
        img[14] = 32'hD00D0003;
        if (sw) for (int i = 0; i < 15; i++) img[i] = rev32(img[i]);
    endtask

    task automatic run(input int n, input int claimed, input bit busy);
        @(negedge clk);
        n_wr = 0; done_cnt = 0; start_cnt = 0; err_last = '0;
        start = 1'b1; img_words = IMG_W'(claimed); eng_running = busy;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = img[i];
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        eng_running = 1'b0;
    endtask

    task automatic chk_result(input string req, input int code, input int nw);
        chk(done_cnt == 1, req, done_cnt, 1);
        chk(err_last == code, req, err_last, code);
        chk(n_wr == nw, req, n_wr, nw);
        chk(start_cnt == ((code == 0) ? 1 : 0), req, start_cnt, (code == 0) ? 1 : 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(wr_en == 1'b0, "R12", wr_en, 0);
        chk(done == 1'b0, "R12", done, 0);
        chk(eng_start == 1'b0, "R12", eng_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(err_code == 4'd0, "R12", err_code, 0);

        // header vectors: R1 R2 R3, successful ones check R8 R10, errors check R11
        for (int v = 0; v < 8; v++) begin
            int claim;
            build_std(VEC[v][15], VEC[v][14], VEC[v][13:10], VEC[v][9:6]);
            claim = 15 + ((VEC[v][5:4] == 2'd1) ? 1 : 0) - ((VEC[v][5:4] == 2'd2) ? 1 : 0);
            run(15, claim, 1'b0);
            chk_result("R1/R2/R3 vector", int'(VEC[v][3:0]), (VEC[v][3:0] == 4'd0) ? 3 : 0);
            if (VEC[v][3:0] == 4'd0) begin
                chk(done_at == last_acc, "R10 timing", done_at, last_acc);
                chk(log_dm[0] == 1'b0 && log_ad[0] == 11'h10 && log_da[0] == 32'hA0A00001, "R8", log_da[0], 32'hA0A00001);
                chk(log_dm[1] == 1'b0 && log_ad[1] == 11'h11 && log_da[1] == 32'hA0A00002, "R8", log_da[1], 32'hA0A00002);
                chk(log_dm[2] == 1'b1 && log_ad[2] == 11'h7FF && log_da[2] == 32'hD00D0003, "R7 R8 exact fit", log_da[2], 32'hD00D0003);
            end
        end

        // R9: busy
        build_std(1'b0, 1'b0, 4'd2, 4'd0);
        run(15, 15, 1'b1);
        chk_result("R9", 7, 0);

        // R4: bad type
        hdr(2); img[3] = 32'd2; img[4] = 32'd0;
        run(5, 5, 1'b0);
        chk_result("R4", 5, 0);

        // R5: payload ends before end word
        hdr(4); img[3] = 0; img[4] = 2; img[5] = 1; img[6] = 2;
        run(7, 7, 1'b0);
        chk_result("R5", 8, 0);

        // R5: too many descriptors
        hdr(20);
        for (int k = 0; k < 9; k++) begin img[3+2*k] = 0; img[4+2*k] = 0; end
        run(23, 23, 1'b0);
        chk_result("R5 table full", 8, 0);

        // R6: offset before table end
        hdr(6); img[3] = 0; img[4] = 2; img[5] = 32'hF; img[6] = 1; img[7] = 1; img[8] = 5;
        run(9, 9, 1'b0);
        chk_result("R6", 4, 0);

        // R7: instruction memory overflow
        hdr(7); img[3] = 0; img[4] = 3; img[5] = 32'hF; img[6] = 32'h7FF; img[7] = 2; img[8] = 1; img[9] = 2;
        run(10, 10, 1'b0);
        chk_result("R7", 6, 0);

        // R2: block runs past payload
        hdr(7); img[3] = 0; img[4] = 3; img[5] = 32'hF; img[6] = 0; img[7] = 5; img[8] = 1; img[9] = 2;
        run(10, 10, 1'b0);
        chk_result("R2 block fit", 2, 0);

        // R13: gap skip, zero-length block, trailing words
        hdr(12);
        img[3] = 1; img[4] = 5; img[5] = 0; img[6] = 8; img[7] = 32'hF;
        img[8] = 3; img[9] = 0; img[10] = 32'h5555AAAA;
        img[11] = 32'h20; img[12] = 1; img[13] = 32'h0000BEEF; img[14] = 32'h77777777;
        run(15, 15, 1'b0);
        chk_result("R13", 0, 1);
        chk(log_dm[0] == 1'b0 && log_ad[0] == 11'h20 && log_da[0] == 32'h0000BEEF, "R13", log_da[0], 32'h0000BEEF);
        chk(done_at == last_acc, "R10 trailing", done_at, last_acc);

        // R6: descending offsets leave a block unreached
        hdr(11);
        img[3] = 0; img[4] = 8; img[5] = 0; img[6] = 5; img[7] = 32'hF;
        img[11] = 1; img[12] = 1; img[13] = 32'hCAFE0001;
        run(14, 14, 1'b0);
        chk_result("R6 order", 4, 1);
        chk(log_ad[0] == 11'h1 && log_da[0] == 32'hCAFE0001, "R6 order", log_da[0], 32'hCAFE0001);

        // R10: end word as last word, no blocks
        hdr(1); img[3] = 32'hF;
        run(4, 4, 1'b0);
        chk_result("R10 empty", 0, 0);

        // R11: words after error are ignored even if they look like a new image
        hdr(2); img[3] = 32'h9; img[4] = SIG;
        run(5, 5, 1'b0);
        repeat (2) @(negedge clk);
        chk(n_wr == 0 && done_cnt == 1, "R11", n_wr, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule